// File: doc/BRIEF.md
# Channel Program Word Checker

This block inspects the control words a channel fetches while running a channel program, and it does so before any of them reaches a subchannel. Four kinds of word can be presented:

- the channel address word that starts an operation;
- a 64-bit channel command word, together with the address it was fetched from and the two storage keys;
- the first indirect data address word of a command;
- a later indirect data address word, fetched when the transfer crosses a page.

Context flags supplied with each request say whether the command is the first of a start operation, whether the previous command was a transfer-in-channel, and whether the command reads backward. The block then reports one of three verdicts: accepted, program check or protection check. For an accepted command word it also reports whether the command is a transfer-in-channel and whether the program-controlled-interruption flag was set.

A request is taken only while the checker is idle. The checker runs a three-state machine:

- `ST_IDLE`: waits for a request. It moves to `ST_EVAL` when `req_valid` is high, latching all request inputs.
- `ST_EVAL`: computes the verdict and registers it. It always moves on to `ST_REPORT`.
- `ST_REPORT`: presents the verdict with `res_valid` high. It always returns to `ST_IDLE`.

Bit numbers in this brief count from the most significant bit, starting at 0. Bit n of the 64-bit command word is therefore `req_word[63-n]`. Address words and indirect words use the low 32 bits of `req_word`, so bit n of such a word is `req_word[31-n]`.

Top module: `chan_word_checker`

## Requirements
- R1: After reset, `res_valid`, `res_pass`, `res_tic` and `res_pci` are 0 and `res_class` is 0.
- R2: Request kind code 0 is an address word. It fails with program check (class 1) when any of its bits 4 to 7 (`req_word[27:24]`) or bits 29 to 31 (`req_word[2:0]`) is nonzero. Otherwise it passes with class 0.
- R3: Request kind code 1 is a command word. Its fetch address must be a multiple of 8 and must be below `MEM_BYTES`; a violation of either is a program check. The access key must equal the storage key; a mismatch is a protection check (class 2). The checks are ranked alignment, then range, then key, then word content, and only the first failure found is reported.
- R4: A command word whose bit 38 or bit 39 (`req_word[25:24]`) is nonzero fails with program check.
- R5: A command word is a transfer-in-channel when the low four bits of its command code (`req_word[59:56]`) are 1000. Such a command fails with program check when `req_first_cmd` is 1.
- R6: A transfer-in-channel command fails with program check when `req_prev_tic` is 1. A transfer-in-channel command that passes raises `res_tic`.
- R7: Request kind code 2 is a first indirect word. Its fetch address must be a multiple of 4 and below `MEM_BYTES` (program check otherwise), and the keys must match (protection check otherwise). Its bits 0 to 7 (`req_word[31:24]`) must be zero (program check otherwise).
- R8: Request kind code 3 is a later indirect word. It fails with program check when its bits 0 to 7 are nonzero. It also fails with program check when its bits 21 to 31 (`req_word[10:0]`) are not all zeros with `req_read_bwd` at 0, or not all ones with `req_read_bwd` at 1.
- R9: `res_pci` equals command-word bit 36 (`req_word[27]`) for an accepted command word. It is 0 for a failed word and for every other kind.
- R10: The verdict appears with `res_valid` high exactly two clock edges after the edge that takes the request, and `res_valid` stays high for one cycle only.
- R11: A request presented while the checker is not idle is ignored: it neither changes the pending verdict nor produces a result of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 2 | 0 address word, 1 command word, 2 first indirect word, 3 later indirect word |
| req_word | input | 64 | Word under test (low 32 bits for 32-bit kinds) |
| req_addr | input | ADDR_W | Fetch address of the word |
| req_acc_key | input | KEY_W | Key of the channel program |
| req_stor_key | input | KEY_W | Key of the fetched storage block |
| req_first_cmd | input | 1 | Command is the first of a start operation |
| req_prev_tic | input | 1 | Previous command was a transfer-in-channel |
| req_read_bwd | input | 1 | Current command reads backward |
| res_valid | output | 1 | Verdict valid strobe |
| res_pass | output | 1 | Word accepted |
| res_class | output | 2 | 0 none, 1 program check, 2 protection check |
| res_tic | output | 1 | Accepted word is a transfer-in-channel |
| res_pci | output | 1 | Program-controlled-interruption request |

## Verification
The bench builds the checker with its defaults: a 24-bit address and a 65536-byte storage limit. With these values the last doubleword below the limit and the first address at the limit are both easy to reach, so the range edge of R3 is tested from both sides. Four-bit keys let a single differing key pair exercise the protection path. Combined faults (misaligned with a wrong key, wrong key with reserved bits set) are sent to pin down the ranking of checks.

// File: rtl/chan_word_pkg.sv
package chan_word_pkg;

    typedef enum logic [1:0] {
        KIND_CAW   = 2'd0,
        KIND_CCW   = 2'd1,
        KIND_IDAW1 = 2'd2,
        KIND_IDAWN = 2'd3
    } word_kind_e;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_PROG = 2'd1,
        CLS_PROT = 2'd2
    } chk_class_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVAL   = 2'd1,
        ST_REPORT = 2'd2
    } chk_state_e;

    localparam int CCW_ALIGN_BITS  = 3;
    localparam int IDAW_ALIGN_BITS = 2;
    localparam logic [3:0] TIC_NIBBLE = 4'b1000;

endpackage

// File: rtl/cw_fetch_rules.sv
module cw_fetch_rules
    import chan_word_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int KEY_W     = 4,
    parameter int MEM_BYTES = 65536
) (
    input  word_kind_e          kind,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [KEY_W-1:0]    acc_key,
    input  logic [KEY_W-1:0]    stor_key,
    output chk_class_e          fetch_cls
);
    localparam logic [ADDR_W:0] LIMIT = ADDR_W'(MEM_BYTES);

    logic misaligned;
    logic beyond;
    logic key_bad;
    logic checked;

    always_comb begin
        checked    = (kind == KIND_CCW) || (kind == KIND_IDAW1);
        misaligned = (kind == KIND_CCW)
                   ? (addr[CCW_ALIGN_BITS-1:0]  != '0)
                   : (addr[IDAW_ALIGN_BITS-1:0] != '0);
        beyond     = ({1'b0, addr} >= LIMIT);
        key_bad    = (acc_key != stor_key);
    end

    always_comb begin
        fetch_cls = CLS_NONE;
        if (checked) begin
            if (misaligned)   fetch_cls = CLS_PROG;
            else if (beyond)  fetch_cls = CLS_PROG;
            else if (key_bad) fetch_cls = CLS_PROT;
        end
    end
endmodule

// File: rtl/cw_content_rules.sv
module cw_content_rules
    import chan_word_pkg::*;
(
    input  word_kind_e   kind,
    input  logic [63:0]  word,
    input  logic         first_cmd,
    input  logic         prev_tic,
    input  logic         read_bwd,
    output logic         content_bad,
    output logic         is_tic,
    output logic         pci_bit
);
    logic [31:0] w32;
    logic        tail_zero;
    logic        tail_ones;
    logic        high_byte_bad;

    always_comb begin
        w32           = word[31:0];
        is_tic        = (word[59:56] == TIC_NIBBLE);
        pci_bit       = word[27];
        high_byte_bad = (w32[31:24] != 8'h00);
        tail_zero     = (w32[10:0] == 11'h000);
        tail_ones     = (w32[10:0] == 11'h7FF);
    end

    always_comb begin
        content_bad = 1'b0;
        unique case (kind)
            KIND_CAW:   content_bad = (w32[27:24] != 4'h0) || (w32[2:0] != 3'h0);
            KIND_CCW:   content_bad = (word[25:24] != 2'b00)
                                    || (is_tic && (first_cmd || prev_tic));
            KIND_IDAW1: content_bad = high_byte_bad;
            KIND_IDAWN: content_bad = high_byte_bad
                                    || (read_bwd ? !tail_ones : !tail_zero);
            default:    content_bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/chan_word_checker.sv
module chan_word_checker
    import chan_word_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int KEY_W     = 4,
    parameter int MEM_BYTES = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [63:0]       req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [KEY_W-1:0]  req_acc_key,
    input  logic [KEY_W-1:0]  req_stor_key,
    input  logic              req_first_cmd,
    input  logic              req_prev_tic,
    input  logic              req_read_bwd,
    output logic              res_valid,
    output logic              res_pass,
    output logic [1:0]        res_class,
    output logic              res_tic,
    output logic              res_pci
);
    chk_state_e        state, state_nx;
    word_kind_e        lat_kind;
    logic [63:0]       lat_word;
    logic [ADDR_W-1:0] lat_addr;
    logic [KEY_W-1:0]  lat_akey, lat_skey;
    logic              lat_first, lat_ptic, lat_rbwd;

    chk_class_e fetch_cls, v_cls;
    logic       content_bad, is_tic, pci_bit;
    logic       v_pass, v_tic, v_pci;

    cw_fetch_rules #(
        .ADDR_W(ADDR_W), .KEY_W(KEY_W), .MEM_BYTES(MEM_BYTES)
    ) u_fetch (
        .kind(lat_kind), .addr(lat_addr), .acc_key(lat_akey),
        .stor_key(lat_skey), .fetch_cls(fetch_cls)
    );

    cw_content_rules u_content (
        .kind(lat_kind), .word(lat_word), .first_cmd(lat_first),
        .prev_tic(lat_ptic), .read_bwd(lat_rbwd),
        .content_bad(content_bad), .is_tic(is_tic), .pci_bit(pci_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_EVAL;
            ST_EVAL:   state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // request capture, only while idle (R11)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_kind  <= KIND_CAW;
            lat_word  <= '0;
            lat_addr  <= '0;
            lat_akey  <= '0;
            lat_skey  <= '0;
            lat_first <= 1'b0;
            lat_ptic  <= 1'b0;
            lat_rbwd  <= 1'b0;
        end else if (state == ST_IDLE && req_valid) begin
            lat_kind  <= word_kind_e'(req_kind);
            lat_word  <= req_word;
            lat_addr  <= req_addr;
            lat_akey  <= req_acc_key;
            lat_skey  <= req_stor_key;
            lat_first <= req_first_cmd;
            lat_ptic  <= req_prev_tic;
            lat_rbwd  <= req_read_bwd;
        end
    end

    // verdict ranking: fetch rules before content rules
    always_comb begin
        if (fetch_cls != CLS_NONE) v_cls = fetch_cls;
        else if (content_bad)      v_cls = CLS_PROG;
        else                       v_cls = CLS_NONE;
        v_pass = (v_cls == CLS_NONE);
        v_tic  = v_pass && (lat_kind == KIND_CCW) && is_tic;
        v_pci  = v_pass && (lat_kind == KIND_CCW) && pci_bit;
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
            res_class <= CLS_NONE;
            res_tic   <= 1'b0;
            res_pci   <= 1'b0;
        end else begin
            res_valid <= (state == ST_EVAL);
            if (state == ST_EVAL) begin
                res_pass  <= v_pass;
                res_class <= v_cls;
                res_tic   <= v_tic;
                res_pci   <= v_pci;
            end
        end
    end

    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid) |=> ##1 res_valid);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    a_r11_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(lat_word) && $stable(lat_kind));
    a_r9_pci_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pci) |-> res_pass);
    a_r6_tic_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_tic) |-> res_pass);
    a_r3_class_matches_pass: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_pass == (res_class == 2'd0)));
endmodule

// File: tb/chan_word_checker_tb.sv
`timescale 1ns/1ps
module chan_word_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [63:0] req_word = '0;
    logic [23:0] req_addr = '0;
    logic [3:0]  req_acc_key = '0;
    logic [3:0]  req_stor_key = '0;
    logic        req_first_cmd = 1'b0;
    logic        req_prev_tic = 1'b0;
    logic        req_read_bwd = 1'b0;
    logic        res_valid, res_pass, res_tic, res_pci;
    logic [1:0]  res_class;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    chan_word_checker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_word(req_word), .req_addr(req_addr), .req_acc_key(req_acc_key),
        .req_stor_key(req_stor_key), .req_first_cmd(req_first_cmd),
        .req_prev_tic(req_prev_tic), .req_read_bwd(req_read_bwd),
        .res_valid(res_valid), .res_pass(res_pass), .res_class(res_class),
        .res_tic(res_tic), .res_pci(res_pci)
    );

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got v/p/c/t/i=%b expected %b", tag, act, exp);
        end
    endtask

    // present at a negedge, take at next posedge, sample two edges later
    task automatic run(input logic [1:0] kind, input logic [63:0] w,
                       input logic [23:0] a, input logic [3:0] ak,
                       input logic [3:0] sk, input logic fc, input logic pt,
                       input logic rb);
        @(negedge clk);
        req_kind = kind; req_word = w; req_addr = a; req_acc_key = ak;
        req_stor_key = sk; req_first_cmd = fc; req_prev_tic = pt;
        req_read_bwd = rb; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_res(string tag, logic p, logic [1:0] c, logic t, logic i);
        check(tag, {res_valid, res_pass, res_class, res_tic, res_pci},
              {1'b1, p, c, t, i});
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 reset", {res_valid, res_pass, res_class, res_tic, res_pci}, 6'b0);
    endtask

    task automatic t_caw;
        run(2'd0, 64'h0000_0000_0000_1000, 24'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        expect_res("R2 caw good", 1'b1, 2'd0, 1'b0, 1'b0);
        run(2'd0, 64'h0000_0000_0100_1000, 24'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        expect_res("R2 caw bit7", 1'b0, 2'd1, 1'b0, 1'b0);
        run(2'd0, 64'h0000_0000_0000_1004, 24'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        expect_res("R2 caw bit29", 1'b0, 2'd1, 1'b0, 1'b0);
    endtask

    task automatic t_ccw_fetch;
        run(2'd1, 64'h0200_1000_0000_0050, 24'h00FFF8, 4'h3, 4'h3, 1'b1, 1'b0, 1'b0);
        expect_res("R3 ccw last dword", 1'b1, 2'd0, 1'b0, 1'b0);
        run(2'd1, 64'h0200_1000_0000_0050, 24'h010000, 4'h3, 4'h3, 1'b0, 1'b0, 1'b0);
        expect_res("R3 ccw at limit", 1'b0, 2'd1, 1'b0, 1'b0);
        run(2'd1, 64'h0200_1000_0000_0050, 24'h000104, 4'h3, 4'h5, 1'b0, 1'b0, 1'b0);
        expect_res("R3 misaligned before key", 1'b0, 2'd1, 1'b0, 1'b0);
        run(2'd1, 64'h0200_1000_0200_0050, 24'h000100, 4'h3, 4'h5, 1'b0, 1'b0, 1'b0);
        expect_res("R3 key before content", 1'b0, 2'd2, 1'b0, 1'b0);
    endtask

    task automatic t_ccw_content;
        run(2'd1, 64'h0200_1000_0200_0050, 24'h000100, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        expect_res("R4 bit38", 1'b0, 2'd1, 1'b0, 1'b0);
        run(2'd1, 64'h0200_1000_0100_0050, 24'h000100, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        expect_res("R4 bit39", 1'b0, 2'd1, 1'b0, 1'b0);
        run(2'd1, 64'h0200_1000_0800_0050, 24'h000100, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        expect_res("R9 pci passed", 1'b1, 2'd0, 1'b0, 1'b1);
    endtask

    task automatic t_tic;
        run(2'd1, 64'h0800_2000_0000_0000, 24'h000100, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
        expect_res("R5 tic first", 1'b0, 2'd1, 1'b0, 1'b0);
        run(2'd1, 64'h1800_2000_0000_0000, 24'h000100, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0);
        expect_res("R6 tic after tic", 1'b0, 2'd1, 1'b0, 1'b0);
        run(2'd1, 64'h0800_2000_0800_0000, 24'h000100, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        expect_res("R6 tic accepted", 1'b1, 2'd0, 1'b1, 1'b1);
    endtask

    task automatic t_idaw_first;
        run(2'd2, 64'h0000_0000_0000_4000, 24'h000104, 4'h2, 4'h2, 1'b0, 1'b0, 1'b0);
        expect_res("R7 idaw word aligned", 1'b1, 2'd0, 1'b0, 1'b0);
        run(2'd2, 64'h0000_0000_0000_4000, 24'h000102, 4'h2, 4'h2, 1'b0, 1'b0, 1'b0);
        expect_res("R7 idaw misaligned", 1'b0, 2'd1, 1'b0, 1'b0);
        run(2'd2, 64'h0000_0000_0000_4000, 24'h000104, 4'h2, 4'h7, 1'b0, 1'b0, 1'b0);
        expect_res("R7 idaw key", 1'b0, 2'd2, 1'b0, 1'b0);
        run(2'd2, 64'h0000_0000_8000_4000, 24'h000104, 4'h2, 4'h2, 1'b0, 1'b0, 1'b0);
        expect_res("R7 idaw high byte", 1'b0, 2'd1, 1'b0, 1'b0);
    endtask

    task automatic t_idaw_next;
        run(2'd3, 64'h0000_0000_0000_3000, 24'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        expect_res("R8 forward zeros", 1'b1, 2'd0, 1'b0, 1'b0);
        run(2'd3, 64'h0000_0000_0000_37FF, 24'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        expect_res("R8 forward ones", 1'b0, 2'd1, 1'b0, 1'b0);
        run(2'd3, 64'h0000_0000_0000_37FF, 24'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1);
        expect_res("R8 backward ones", 1'b1, 2'd0, 1'b0, 1'b0);
        run(2'd3, 64'h0000_0000_0000_3000, 24'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1);
        expect_res("R8 backward zeros", 1'b0, 2'd1, 1'b0, 1'b0);
        run(2'd3, 64'h0800_0000_0100_3000, 24'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        expect_res("R8 high byte, R9 no pci", 1'b0, 2'd1, 1'b0, 1'b0);
    endtask

    task automatic t_timing_busy;
        @(negedge clk);
        req_kind = 2'd0; req_word = 64'h0000_0000_0000_1000; req_valid = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 early result: got %b expected 0", res_valid);
        end
        req_word = 64'h0000_0000_0F00_1007;   // bad word while busy
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 R11 first verdict kept", {res_valid, res_pass, res_class, res_tic, res_pci},
              6'b110000);
        @(negedge clk);
        check("R10 one cycle", {res_valid, 5'b0}, 6'b0);
        @(negedge clk);
        @(negedge clk);
        check("R11 no extra result", {res_valid, 5'b0}, 6'b0);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_caw();
        t_ccw_fetch();
        t_ccw_content();
        t_tic();
        t_idaw_first();
        t_idaw_next();
        t_timing_busy();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule